// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses that a synchronous DRAM controller walks through inside one open row while a read or write burst is in progress. A burst command supplies a start column, a burst length code and an ordering choice. On each following clock the block presents one column address, a valid strobe and a flag that marks the final beat of the burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns. The group is walked either in wrapping increment order or in XOR (interleaved) order. A full-page burst steps through every column of the row, wraps from the top column back to zero, and runs until it is told to stop. A stop input ends any burst early. A fresh burst command that arrives while a burst is running abandons the old sequence at once and starts the new one.

Top module: `burst_colgen`

## Requirements
- R1: While and after synchronous reset, with no command given, `valid_o` and `last_o` are low.
- R2: In the cycle after `start_i` is high, `valid_o` is high and `col_o` equals the `start_col_i` sampled with the command.
- R3: The length code `blen_i` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Any code from 4 to 7 selects full-page mode.
- R4: With `interleave_i` low, a fixed burst of N beats increments the low log2(N) column bits modulo N on each beat. The upper column bits stay at the start value.
- R5: With `interleave_i` high, beat k of a fixed burst of N beats outputs the start column with its low log2(N) bits XORed with k.
- R6: A full-page burst increments the column by one on each beat, from 255 to 0 for an 8-bit column, whatever the value of `interleave_i`. It continues until it is stopped or restarted.
- R7: `last_o` is high exactly on the final beat of a fixed burst and never in full-page mode. `valid_o` drops in the cycle after the final beat.
- R8: `stop_i` high during a beat drops `valid_o` in the next cycle. While the block is idle, `stop_i` has no effect on the outputs.
- R9: `start_i` during a running burst restarts the sequence from the new start column in the next cycle. `start_i` takes priority over `stop_i` when both are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst command strobe |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects XOR ordering, 0 selects wrapping increment |
| stop_i | input | 1 | Ends the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | A column beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A wrong latched start column, length mask or ordering bit shows up at the second beat of a burst as a wrong `col_o`. A wrong beat counter shows up as `last_o` asserted on the wrong beat, or as `valid_o` staying high one cycle too long, within at most eight beats of a fixed burst. Full-page wrap faults appear only when the run crosses the top column, so the bench runs that mode through several full rows. Every output is compared against a behavioural model on every clock, so a fault is reported in the first cycle it becomes visible.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
  localparam int BLEN_W = 3;
  // burst length codes; bit 2 set means full page
  localparam logic [BLEN_W-1:0] BLEN_1    = 3'd0;
  localparam logic [BLEN_W-1:0] BLEN_2    = 3'd1;
  localparam logic [BLEN_W-1:0] BLEN_4    = 3'd2;
  localparam logic [BLEN_W-1:0] BLEN_8    = 3'd3;
  localparam logic [BLEN_W-1:0] BLEN_PAGE = 3'd7;
endpackage

// File: rtl/burst_colgen_cfg.sv
module burst_colgen_cfg
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [BLEN_W-1:0] code_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o
);
  localparam int LG_W = BLEN_W - 1;

  logic [LG_W-1:0] lg;

  always_comb begin
    full_o = code_i[BLEN_W-1];
    lg     = code_i[LG_W-1:0];
  end

  // mask of the wrapping low bits: lg ones, or all ones for full page
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o || (i < int'(lg));
  end
endmodule

// File: rtl/burst_colgen_addr.sv
module burst_colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv_i && !full_i) low = base_i ^ beat_i;
    else                  low = base_i + beat_i;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [BLEN_W-1:0] blen_i,
  input  logic              interleave_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [COL_W-1:0] mask_d, mask_q;
  logic             full_d, full_q;
  logic [COL_W-1:0] base_q, beat_q, beat_nxt, col_nxt;
  logic             ilv_q;

  burst_colgen_cfg #(.COL_W(COL_W)) u_cfg (
    .code_i (blen_i),
    .mask_o (mask_d),
    .full_o (full_d)
  );

  assign beat_nxt = beat_q + 1'b1;

  burst_colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .beat_i (beat_nxt),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .full_i (full_q),
    .col_o  (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      col_o   <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      mask_q  <= mask_d;
      full_q  <= full_d;
      ilv_q   <= interleave_i;
      beat_q  <= '0;
      col_o   <= start_col_i;
      valid_o <= 1'b1;
      last_o  <= !full_d && (mask_d == '0);
    end else if (valid_o && (stop_i || last_o)) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (valid_o) begin
      beat_q  <= beat_nxt;
      col_o   <= col_nxt;
      last_o  <= !full_q && (beat_nxt == mask_q);
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o); // R7

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (rst)
    (valid_o && full_q) |-> !last_o); // R7

  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o); // R7

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (valid_o && stop_i && !start_i) |=> !valid_o); // R8

  AST_START_COL: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !stop_i && !start_i)
      |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))); // R4
endmodule

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;
  localparam int COL_W = 8;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = '0;
  logic             interleave_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk, .rst, .start_i, .start_col_i, .blen_i, .interleave_i, .stop_i,
    .col_o, .valid_o, .last_o
  );

  always #4 clk = ~clk;  // 125 MHz

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";

  // behavioural reference
  int ref_valid = 0, ref_base = 0, ref_beat = 0, ref_len = 1, ref_ilv = 0, ref_full = 0;

  always @(posedge clk) begin
    if (rst) begin
      ref_valid = 0;
    end else if (start_i) begin
      ref_base  = int'(start_col_i);
      ref_beat  = 0;
      ref_full  = (blen_i >= 3'd4) ? 1 : 0;
      ref_len   = ref_full ? NCOL : (1 << blen_i);
      ref_ilv   = int'(interleave_i);
      ref_valid = 1;
    end else if (ref_valid != 0 && (stop_i || (ref_full == 0 && ref_beat == ref_len - 1))) begin
      ref_valid = 0;
    end else if (ref_valid != 0) begin
      ref_beat = (ref_beat + 1) % NCOL;
    end
  end

  function automatic int exp_col();
    int low;
    if (ref_full != 0) return (ref_base + ref_beat) % NCOL;
    if (ref_ilv != 0) low = (ref_base % ref_len) ^ ref_beat;
    else              low = ((ref_base % ref_len) + ref_beat) % ref_len;
    return ref_base - (ref_base % ref_len) + low;
  endfunction

  always @(negedge clk) begin
    int e_col, e_last;
    e_last = (ref_valid != 0 && ref_full == 0 && ref_beat == ref_len - 1) ? 1 : 0;
    n_checks++;
    if (int'(valid_o) != ref_valid || int'(last_o) != e_last) begin
      n_fail++;
      $display("FAIL %s valid/last actual %0d/%0d expected %0d/%0d",
               tag, valid_o, last_o, ref_valid, e_last);
    end else if (ref_valid != 0) begin
      e_col = exp_col();
      if (int'(col_o) != e_col) begin
        n_fail++;
        $display("FAIL %s col actual %0d expected %0d", tag, col_o, e_col);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic burst(input logic [COL_W-1:0] c, input logic [2:0] code, input logic ilv);
    start_i = 1'b1; start_col_i = c; blen_i = code; interleave_i = ilv;
    step();
    start_i = 1'b0; interleave_i = ~ilv;  // later value must not matter
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    tag = "R1"; step(3);
    stop_i = 1'b1; tag = "R8"; step(2); stop_i = 1'b0;          // stop while idle
    tag = "R2"; burst(8'h2D, 3'd3, 1'b0); step(10);
    tag = "R4"; burst(8'hA6, 3'd2, 1'b0); step(6);
    tag = "R3";
    for (int code = 0; code < 4; code++) begin
      burst(8'h47, 3'(code), 1'b0); step(10);
    end
    tag = "R5"; burst(8'h13, 3'd2, 1'b1); step(6);
    burst(8'h5E, 3'd3, 1'b1); step(10);
    burst(8'hC3, 3'd1, 1'b1); step(4);
    tag = "R6"; burst(8'hFC, 3'd7, 1'b1); step(600);
    tag = "R8"; stop_i = 1'b1; step(); stop_i = 1'b0; step(3);
    tag = "R3"; burst(8'h10, 3'd5, 1'b0); step(20);
    tag = "R9"; burst(8'h80, 3'd3, 1'b0); step(2);
    tag = "R7"; burst(8'hFF, 3'd1, 1'b0); step(4);
    burst(8'h22, 3'd0, 1'b1); step(3);
    tag = "R8"; burst(8'h64, 3'd3, 1'b1); step(3);
    stop_i = 1'b1; step(); stop_i = 1'b0; step(3);
    tag = "R9"; burst(8'h10, 3'd3, 1'b0); step(3);
    burst(8'h37, 3'd2, 1'b1); step(1);
    stop_i = 1'b1; burst(8'h90, 3'd3, 1'b0); stop_i = 1'b0; step(10);
    burst(8'hF0, 3'd7, 1'b0); step(5);
    burst(8'h05, 3'd3, 1'b1); step(10);
    finish_run();
  end
endmodule